// File: doc/BRIEF.md
# A/D Conversion Sequencer and Completion-Interrupt Register Block

This block sits between a byte-wide processor bus and an external successive-approximation A/D converter. Software programs a conversion-clock gate, picks one of four analog inputs, and requests a conversion. The block turns that request into a single-cycle start pulse for the converter. It holds the channel number steady while the conversion runs, and captures the 10-bit result when the converter signals that it has finished.

Each finished conversion latches a completion flag. The flag is set whatever the interrupt settings are, and software clears it by writing 1. The block raises an interrupt request while three things are true: the flag is set, the interrupt is enabled, and the programmed 2-bit priority is strictly above the CPU's current interrupt level. Start requests made while the conversion clock is gated off are kept until the clock is enabled. Start requests made during a running conversion are dropped.

Register map (byte addresses): 0 clock gate (bit 0), 1 conversion control (bit 7 start, bits 1..0 channel), 2 result high byte, 3 result low byte, 4 interrupt priority (bits 1..0), 5 interrupt enable (bit 0), 6 completion flag (bit 0). Any other address reads 0.

Top module: `adc_ctl_top`

## Requirements
- R1: After reset, conv_clk_en, conv_start and irq_req are 0, and addresses 1, 4, 5 and 6 all read 0x00.
- R2: Bit 0 written at address 0 drives conv_clk_en directly; reading address 0 always returns 0x00.
- R3: Writing address 1 with bit 7 set, while the clock gate is on and nothing is busy, gives conv_start high for exactly one cycle, in the second cycle after the write edge. Writing bit 7 as 0 starts nothing, and bit 7 always reads 0.
- R4: Bits 1..0 of address 1 are a readable channel field; codes 0,1,2,3 select analog inputs 4,5,6,7. conv_chan shows the field value captured at the start pulse and holds it until the conversion ends, even if the field is rewritten meanwhile.
- R5: A start written while conv_clk_en is 0 stays pending; conv_start then fires on the second edge after the write that enables the clock.
- R6: A start written while a conversion is in progress is discarded and causes no later conv_start.
- R7: A conv_done pulse during a conversion captures conv_data. Address 2 reads result bits 9..2, and address 3 reads bits 1..0 in D1..D0 with D7..D2 zero. A conv_done with no conversion running changes nothing.
- R8: The completion flag (address 6, bit 0) is set by an accepted conv_done regardless of enable and priority. Writing 1 clears it; writing 0 leaves it unchanged.
- R9: If an accepted conv_done and a flag clear happen in the same cycle, the flag ends up 1.
- R10: Priority (address 4, bits 1..0) and interrupt enable (address 5, bit 0) read back the values written.
- R11: irq_req is 1 exactly when the flag is 1, the enable is 1 and the priority is greater than cpu_level; it follows cpu_level in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and control clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register byte address |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| cpu_level | input | 2 | CPU's current interrupt mask level |
| conv_clk_en | output | 1 | Conversion clock gate to the converter |
| conv_start | output | 1 | Single-cycle conversion start |
| conv_chan | output | 2 | Channel code for the running conversion |
| conv_done | input | 1 | Converter finished, one cycle |
| conv_data | input | 10 | Conversion result, valid with conv_done |
| irq_req | output | 1 | Completion interrupt request |

## Verification
A stuck or lost pending bit appears as a missing or extra conv_start within two cycles of the enabling write. A wrong busy state shows up in two ways: a start that should have been dropped but fires, or a conv_done that is wrongly ignored, leaving the result bytes and the flag unchanged at the next read. Flag or priority faults show at irq_req in the same cycle that cpu_level, the enable or the priority changes. The comparison is therefore swept over a table of level combinations, with the flag held set.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;
    localparam int ADDR_W    = 3;
    localparam int DATA_W    = 8;
    localparam int START_BIT = 7;

    localparam logic [ADDR_W-1:0] A_CLK  = 3'd0;
    localparam logic [ADDR_W-1:0] A_CONV = 3'd1;
    localparam logic [ADDR_W-1:0] A_RHI  = 3'd2;
    localparam logic [ADDR_W-1:0] A_RLO  = 3'd3;
    localparam logic [ADDR_W-1:0] A_PRI  = 3'd4;
    localparam logic [ADDR_W-1:0] A_IEN  = 3'd5;
    localparam logic [ADDR_W-1:0] A_FLG  = 3'd6;
endpackage

// File: rtl/adc_regs.sv
module adc_regs
    import adc_ctl_pkg::*;
#(
    parameter int RES_W  = 10,
    parameter int CHAN_W = 2,
    parameter int PRI_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [RES_W-1:0]  result,
    input  logic              flag,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              clk_en,
    output logic [CHAN_W-1:0] chan,
    output logic [PRI_W-1:0]  pri,
    output logic              ien,
    output logic              start_req,
    output logic              flag_clr
);
    localparam int LO_W = RES_W - DATA_W;

    typedef struct packed {
        logic              clk_en;
        logic [CHAN_W-1:0] chan;
        logic [PRI_W-1:0]  pri;
        logic              ien;
    } regs_t;

    regs_t r_d, r_q;
    logic  start_d, clr_d;
    logic [DATA_W-1:0] rd_d;

    always_comb begin
        r_d     = r_q;
        start_d = 1'b0;
        clr_d   = 1'b0;
        if (bus_wr) begin
            unique case (bus_addr)
                A_CLK:  r_d.clk_en = bus_wdata[0];
                A_CONV: begin
                    r_d.chan = bus_wdata[CHAN_W-1:0];
                    start_d  = bus_wdata[START_BIT];
                end
                A_PRI:  r_d.pri = bus_wdata[PRI_W-1:0];
                A_IEN:  r_d.ien = bus_wdata[0];
                A_FLG:  clr_d   = bus_wdata[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rd_d = '0;
        unique case (bus_addr)
            A_CONV: rd_d[CHAN_W-1:0] = r_q.chan;
            A_RHI:  rd_d = result[RES_W-1 -: DATA_W];
            A_RLO:  rd_d[LO_W-1:0] = result[LO_W-1:0];
            A_PRI:  rd_d[PRI_W-1:0] = r_q.pri;
            A_IEN:  rd_d[0] = r_q.ien;
            A_FLG:  rd_d[0] = flag;
            default: ;
        endcase
    end

    assign bus_rdata = rd_d;
    assign clk_en    = r_q.clk_en;
    assign chan      = r_q.chan;
    assign pri       = r_q.pri;
    assign ien       = r_q.ien;
    assign start_req = start_d;
    assign flag_clr  = clr_d;

    // R2
    clk_gate_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CLK) |=> (clk_en == $past(bus_wdata[0])));
endmodule

// File: rtl/adc_seq.sv
module adc_seq #(
    parameter int CHAN_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              clk_en,
    input  logic [CHAN_W-1:0] chan,
    input  logic              conv_done,
    output logic              conv_start,
    output logic [CHAN_W-1:0] conv_chan,
    output logic              done_acc
);
    typedef struct packed {
        logic              pending;
        logic              busy;
        logic              start;
        logic [CHAN_W-1:0] cur_chan;
    } seq_t;

    seq_t s_d, s_q;
    logic acc;

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        acc       = s_q.busy && conv_done;
        if (acc) s_d.busy = 1'b0;
        if (start_req && !s_q.busy) s_d.pending = 1'b1;
        if (s_q.pending && clk_en && !s_q.busy) begin
            s_d.pending  = 1'b0;
            s_d.busy     = 1'b1;
            s_d.start    = 1'b1;
            s_d.cur_chan = chan;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign conv_start = s_q.start;
    assign conv_chan  = s_q.cur_chan;
    assign done_acc   = acc;

    // R3
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);
    // R5
    start_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> clk_en);
    // R4
    chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !conv_start && $past(s_q.busy)) |-> $stable(conv_chan));
    // R6
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !s_q.pending && start_req) |=> !s_q.pending);
endmodule

// File: rtl/adc_res_irq.sv
module adc_res_irq #(
    parameter int RES_W = 10,
    parameter int PRI_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done_acc,
    input  logic [RES_W-1:0] conv_data,
    input  logic             flag_clr,
    input  logic             ien,
    input  logic [PRI_W-1:0] pri,
    input  logic [PRI_W-1:0] cpu_level,
    output logic [RES_W-1:0] result,
    output logic             flag,
    output logic             irq_req
);
    typedef struct packed {
        logic [RES_W-1:0] result;
        logic             flag;
    } res_t;

    res_t q_d, q_q;

    always_comb begin
        q_d = q_q;
        if (done_acc) begin
            q_d.result = conv_data;
            q_d.flag   = 1'b1;
        end else if (flag_clr) begin
            q_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign result  = q_q.result;
    assign flag    = q_q.flag;
    assign irq_req = q_q.flag && ien && (pri > cpu_level);

    // R7
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_acc |=> (result == $past(conv_data)));
    // R9
    done_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_acc |=> flag);
    // R8
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !done_acc) |=> !flag);
    // R11
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (flag && ien));
endmodule

// File: rtl/adc_ctl_top.sv
module adc_ctl_top
    import adc_ctl_pkg::*;
#(
    parameter int RES_W  = 10,
    parameter int CHAN_W = 2,
    parameter int PRI_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [PRI_W-1:0]  cpu_level,
    output logic              conv_clk_en,
    output logic              conv_start,
    output logic [CHAN_W-1:0] conv_chan,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_data,
    output logic              irq_req
);
    logic [RES_W-1:0]  result;
    logic              flag, ien, start_req, flag_clr, done_acc;
    logic [CHAN_W-1:0] chan;
    logic [PRI_W-1:0]  pri;

    adc_regs #(.RES_W(RES_W), .CHAN_W(CHAN_W), .PRI_W(PRI_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .result(result), .flag(flag),
        .bus_rdata(bus_rdata), .clk_en(conv_clk_en), .chan(chan), .pri(pri),
        .ien(ien), .start_req(start_req), .flag_clr(flag_clr)
    );

    adc_seq #(.CHAN_W(CHAN_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .clk_en(conv_clk_en),
        .chan(chan), .conv_done(conv_done), .conv_start(conv_start),
        .conv_chan(conv_chan), .done_acc(done_acc)
    );

    adc_res_irq #(.RES_W(RES_W), .PRI_W(PRI_W)) u_res (
        .clk(clk), .rst_n(rst_n), .done_acc(done_acc), .conv_data(conv_data),
        .flag_clr(flag_clr), .ien(ien), .pri(pri), .cpu_level(cpu_level),
        .result(result), .flag(flag), .irq_req(irq_req)
    );
endmodule

// File: tb/tb_adc_ctl_top.sv
module tb_adc_ctl_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] cpu_level = '0;
    logic       conv_clk_en, conv_start, irq_req;
    logic [1:0] conv_chan;
    logic       conv_done = 1'b0;
    logic [9:0] conv_data = '0;

    int total = 0;
    int bad = 0;
    logic [7:0] rv;

    always #10 clk = ~clk;

    adc_ctl_top dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_level(cpu_level),
        .conv_clk_en(conv_clk_en), .conv_start(conv_start), .conv_chan(conv_chan),
        .conv_done(conv_done), .conv_data(conv_data), .irq_req(irq_req)
    );

    // priority, enable, cpu level, expected irq (flag held at 1)
    localparam int NV = 8;
    localparam logic [5:0] VEC [NV] = '{
        {2'd0, 1'b1, 2'd0, 1'b0}, {2'd1, 1'b1, 2'd0, 1'b1},
        {2'd1, 1'b1, 2'd1, 1'b0}, {2'd2, 1'b1, 2'd1, 1'b1},
        {2'd3, 1'b1, 2'd2, 1'b1}, {2'd3, 1'b1, 2'd3, 1'b0},
        {2'd3, 1'b0, 2'd0, 1'b0}, {2'd2, 1'b1, 2'd3, 1'b0}
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic done_pulse(logic [9:0] d);
        @(negedge clk);
        conv_done = 1'b1; conv_data = d;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    task automatic no_start(string req, int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(req, conv_start, 0);
        end
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 clk_en", conv_clk_en, 0);
        check("R1 start", conv_start, 0);
        check("R1 irq", irq_req, 0);
        rd(3'd1, rv); check("R1 conv", rv, 0);
        rd(3'd4, rv); check("R1 pri", rv, 0);
        rd(3'd5, rv); check("R1 ien", rv, 0);
        rd(3'd6, rv); check("R1 flag", rv, 0);

        // R2 clock gate
        wr(3'd0, 8'h01);
        check("R2 gate on", conv_clk_en, 1);
        rd(3'd0, rv); check("R2 reads zero", rv, 0);

        // R3 / R4 start on channel 2
        wr(3'd1, 8'h82);
        check("R3 not yet", conv_start, 0);
        @(negedge clk);
        check("R3 start pulse", conv_start, 1);
        check("R4 chan", conv_chan, 2);
        @(negedge clk);
        check("R3 one cycle", conv_start, 0);
        rd(3'd1, rv); check("R3 start reads 0", rv, 8'h02);
        wr(3'd1, 8'h01);
        check("R4 chan held", conv_chan, 2);
        rd(3'd1, rv); check("R4 field readback", rv, 8'h01);
        // R6 start while busy
        wr(3'd1, 8'h83);
        // R7 capture, R8 flag regardless of enable
        done_pulse(10'h2D6);
        rd(3'd2, rv); check("R7 high byte", rv, 8'hB5);
        rd(3'd3, rv); check("R7 low byte", rv, 8'h02);
        rd(3'd6, rv); check("R8 flag set", rv, 1);
        check("R11 irq off", irq_req, 0);
        no_start("R6 dropped start", 4);
        wr(3'd6, 8'h00);
        rd(3'd6, rv); check("R8 write0 ignored", rv, 1);
        wr(3'd6, 8'h01);
        rd(3'd6, rv); check("R8 cleared", rv, 0);
        // R7 idle done ignored
        done_pulse(10'h3FF);
        rd(3'd2, rv); check("R7 idle done data", rv, 8'hB5);
        rd(3'd6, rv); check("R7 idle done flag", rv, 0);
        // R3 write with bit7=0
        wr(3'd1, 8'h00);
        no_start("R3 zero no start", 3);

        // R5 pending while gated
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h83);
        no_start("R5 held", 3);
        wr(3'd0, 8'h01);
        check("R5 not yet", conv_start, 0);
        @(negedge clk);
        check("R5 released", conv_start, 1);
        check("R4 chan 3", conv_chan, 3);
        done_pulse(10'h001);
        rd(3'd2, rv); check("R7 high byte 2", rv, 8'h00);
        rd(3'd3, rv); check("R7 low byte 2", rv, 8'h01);

        // R9 done and clear together
        wr(3'd1, 8'h80);
        @(negedge clk);
        check("R9 start", conv_start, 1);
        @(negedge clk);
        conv_done = 1'b1; conv_data = 10'h155;
        bus_addr = 3'd6; bus_wdata = 8'h01; bus_wr = 1'b1;
        @(negedge clk);
        conv_done = 1'b0; bus_wr = 1'b0;
        rd(3'd6, rv); check("R9 done wins", rv, 1);
        rd(3'd2, rv); check("R9 result", rv, 8'h55);

        // R10 / R11 table walk with flag set
        for (int i = 0; i < NV; i++) begin
            wr(3'd4, {6'd0, VEC[i][5:4]});
            wr(3'd5, {7'd0, VEC[i][3]});
            cpu_level = VEC[i][2:1];
            rd(3'd4, rv); check("R10 pri", rv, {6'd0, VEC[i][5:4]});
            rd(3'd5, rv); check("R10 ien", rv, {7'd0, VEC[i][3]});
            check("R11 irq", irq_req, VEC[i][0]);
        end
        wr(3'd4, 8'h03); wr(3'd5, 8'h01); cpu_level = 2'd0;
        #1 check("R11 irq high", irq_req, 1);
        wr(3'd6, 8'h01);
        check("R11 irq after clear", irq_req, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule